// File: doc/BRIEF.md
# Coded audio word FIFO with underflow fill pattern

This block is an eight-word, sixteen-bit first-in first-out store that sits between a voice codec core and the bus side of a chip. One instance carries words toward the bus (outgoing direction) and a second carries words from the bus toward the codec (incoming direction). A parameter picks the direction, and the direction decides which warning the block raises. The outgoing copy warns when it is close to full. The incoming copy warns when it is close to running dry.

The warning threshold is three words. That leaves five words of headroom, which fits audio that moves in packets of ten bytes or a multiple of ten. A write into a full store is dropped and leaves the contents as they were. A read from an empty store returns a fixed alternating-bit word instead of stale data, so an audio stream that runs short degrades gently. Along with the level flags, the block gives one-cycle pulses for a dropped write, for an empty read, and for the warning becoming active.

Top module: `audio_word_fifo`

## Requirements
- R1: While and right after synchronous active-low reset: `level`=0, `empty`=1, `full`=0, `rd_data`=0, and `drop_pulse`, `under_pulse` and `warn_rise` are 0. `warn` is 0 in the outgoing direction and 1 in the incoming direction.
- R2: Words are read out in the order they were written. `rd_data` shows the word one clock after the edge that samples `rd_en`, and holds its value while `rd_en` is low.
- R3: The store holds at most 8 words. `level` never exceeds 8, and `full` is 1 exactly when `level` is 8.
- R4: A write while `full` is dropped. `level` and the stored words stay unchanged, and `drop_pulse` is 1 for the cycle after that edge.
- R5: A read while `empty` returns 16'hAAAA (odd bits 1, even bits 0). `level` stays at 0, no word is consumed, and `under_pulse` is 1 for the cycle after that edge.
- R6: Outgoing direction (DIR_OUT): `warn` is 1 exactly when three or fewer free slots remain, that is when `level` is 5 or more.
- R7: Incoming direction (DIR_IN): `warn` is 1 exactly when three or fewer unread words remain, that is when `level` is 3 or less.
- R8: `warn_rise` is 1 for one cycle in the cycle where `warn` changes from 0 to 1, and is 0 at all other times.
- R9: A read and a write on the same edge, while the store is neither full nor empty, both take effect and `level` stays unchanged.
- R10: A read and a write on the same edge while full: the read takes the oldest word and the write is dropped, so `level` becomes 7. The same pair while empty: the write is stored and the read returns 16'hAAAA, so `level` becomes 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 16 | Word to store |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 16 | Word read, or the fill pattern |
| level | output | 4 | Number of stored words |
| full | output | 1 | Store holds 8 words |
| empty | output | 1 | Store holds no word |
| warn | output | 1 | Direction-specific early warning |
| warn_rise | output | 1 | One-cycle pulse when `warn` becomes 1 |
| drop_pulse | output | 1 | One-cycle pulse after a write was dropped |
| under_pulse | output | 1 | One-cycle pulse after a read of an empty store |

## Verification
Every result of this block is registered. `rd_data`, `level`, all flags and all pulses therefore take their new value right after the rising edge that samples the strobes, and they are valid for exactly that one cycle. The bench changes the strobes on the falling edge, waits for one rising edge, and compares every output on the next falling edge, before it applies the next stimulus. Each pulse is checked in the cycle after its cause, and the check confirms that it has cleared again once its cause is gone. The expected warning and pulse values come from the expected level of the current step and the step before it.

// File: rtl/afifo_pkg.sv
// Package afifo_pkg
// Holds the types and helpers shared by the audio word FIFO modules.
// Assumes: no state; this package is only compiled.
package afifo_pkg;

    // Which side the instance serves; this decides the meaning of the warning.
    typedef enum logic {
        DIR_OUT = 1'b0,   // codec to bus: warn near full
        DIR_IN  = 1'b1    // bus to codec: warn near empty
    } dir_e;

    // Build an alternating word: odd bit positions 1, even ones 0 (16 bits -> 16'hAAAA).
    function automatic logic [63:0] alt_pattern(input int unsigned width);
        logic [63:0] v;
        v = '0;
        for (int unsigned i = 0; i < 64; i++) begin
            if (i < width && (i % 2) == 1) v[i] = 1'b1;
        end
        return v;
    endfunction

endpackage

// File: rtl/afifo_ctrl.sv
// Module afifo_ctrl
// Keeps the read and write pointers and the fill level. It turns raw strobes
// into accepted push and pop events: a push is refused when full, and a pop is
// refused when empty.
// Assumes: DEPTH >= 2; the pointers wrap at DEPTH-1 for any depth.
module afifo_ctrl #(
    parameter int DEPTH = 8,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             rd_en,
    output logic             push,
    output logic             pop,
    output logic [PTR_W-1:0] wptr,
    output logic [PTR_W-1:0] rptr,
    output logic [CNT_W-1:0] level,
    output logic [CNT_W-1:0] level_nxt
);

    localparam logic [CNT_W-1:0] LVL_MAX  = CNT_W'(DEPTH);
    localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);

    // Accept events only where they keep the store consistent.
    always_comb begin
        push = wr_en && (level != LVL_MAX);
        pop  = rd_en && (level != '0);
    end

    // Next fill level from the accepted events.
    always_comb begin
        level_nxt = level;
        if (push && !pop)      level_nxt = level + 1'b1;
        else if (pop && !push) level_nxt = level - 1'b1;
    end

    // Register the level and advance the pointers with wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level <= '0;
            wptr  <= '0;
            rptr  <= '0;
        end else begin
            level <= level_nxt;
            if (push) wptr <= (wptr == PTR_LAST) ? '0 : wptr + 1'b1;
            if (pop)  rptr <= (rptr == PTR_LAST) ? '0 : rptr + 1'b1;
        end
    end

    // R3
    level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        level <= LVL_MAX);

    // R9
    both_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && rd_en && level != '0 && level != LVL_MAX) |=> level == $past(level));

    // R5
    empty_stays_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !wr_en && level == '0) |=> level == '0);

    // R4
    full_stays_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !rd_en && level == LVL_MAX) |=> level == LVL_MAX);

endmodule

// File: rtl/afifo_store.sv
// Module afifo_store
// Word storage plus the registered read port. An accepted pop returns the word
// at the read pointer. A read strobe without a pop returns the fill pattern.
// With no read strobe, the read port keeps its value.
// Assumes: push and pop are already qualified by afifo_ctrl.
module afifo_store
    import afifo_pkg::*;
#(
    parameter int WIDTH = 16,
    parameter int DEPTH = 8,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic             pop,
    input  logic             rd_en,
    input  logic [PTR_W-1:0] wptr,
    input  logic [PTR_W-1:0] rptr,
    input  logic [WIDTH-1:0] wr_data,
    output logic [WIDTH-1:0] rd_data
);

    localparam logic [63:0]      PAT_FULL = alt_pattern(WIDTH);
    localparam logic [WIDTH-1:0] FILL_PAT = PAT_FULL[WIDTH-1:0];

    logic [WIDTH-1:0] mem [DEPTH];

    // Store the accepted word; the array itself needs no reset.
    always_ff @(posedge clk) begin
        if (push) mem[wptr] <= wr_data;
    end

    // Drive the read port: the stored word, the fill pattern, or hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else if (rd_en) begin
            rd_data <= pop ? mem[rptr] : FILL_PAT;
        end
    end

    // R5
    fill_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !pop) |=> rd_data == FILL_PAT);

    // R2
    read_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data));

endmodule

// File: rtl/afifo_flags.sv
// Module afifo_flags
// Registers the level flags from the next fill level, so that they line up
// with the level register. It also makes the one-cycle event pulses. The
// warning rule comes from DIR: near full for the outgoing side, near empty
// for the incoming side.
// Assumes: level_nxt and level come from afifo_ctrl; SLACK < DEPTH.
module afifo_flags
    import afifo_pkg::*;
#(
    parameter int   DEPTH = 8,
    parameter int   SLACK = 3,
    parameter dir_e DIR   = DIR_OUT,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic             push,
    input  logic             pop,
    input  logic [CNT_W-1:0] level,
    input  logic [CNT_W-1:0] level_nxt,
    output logic             full,
    output logic             empty,
    output logic             warn,
    output logic             warn_rise,
    output logic             drop_pulse,
    output logic             under_pulse
);

    localparam logic [CNT_W-1:0] LVL_MAX  = CNT_W'(DEPTH);
    localparam logic [CNT_W-1:0] HI_MARK  = CNT_W'(DEPTH - SLACK);
    localparam logic [CNT_W-1:0] LO_MARK  = CNT_W'(SLACK);
    localparam logic             WARN_RST = (DIR == DIR_IN);

    logic warn_nxt;

    // Pick the warning rule for this direction.
    generate
        if (DIR == DIR_OUT) begin : g_near_full
            always_comb warn_nxt = (level_nxt >= HI_MARK);
        end else begin : g_near_empty
            always_comb warn_nxt = (level_nxt <= LO_MARK);
        end
    endgenerate

    // Register the level flags and the event pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full        <= 1'b0;
            empty       <= 1'b1;
            warn        <= WARN_RST;
            warn_rise   <= 1'b0;
            drop_pulse  <= 1'b0;
            under_pulse <= 1'b0;
        end else begin
            full        <= (level_nxt == LVL_MAX);
            empty       <= (level_nxt == '0);
            warn        <= warn_nxt;
            warn_rise   <= warn_nxt && !warn;
            drop_pulse  <= wr_en && !push;
            under_pulse <= rd_en && !pop;
        end
    end

    // R3
    full_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        full == (level == LVL_MAX));

    // R4
    drop_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && full) |=> drop_pulse);

    // R5
    under_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && empty) |=> under_pulse);

    // R8
    warn_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        warn_rise |-> (warn && !$past(warn)));

    // R6 / R7
    generate
        if (DIR == DIR_OUT) begin : g_chk_out
            // R6
            warn_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
                warn == (level >= HI_MARK));
        end else begin : g_chk_in
            // R7
            warn_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
                warn == (level <= LO_MARK));
        end
    endgenerate

endmodule

// File: rtl/audio_word_fifo.sv
// Module audio_word_fifo
// Top of the coded audio word FIFO. It ties the pointer control, the storage
// and the flag logic together. One instance serves each direction, chosen by DIR.
// Assumes: strobes are synchronous to clk; reset is synchronous, active low.
module audio_word_fifo
    import afifo_pkg::*;
#(
    parameter int   WIDTH = 16,
    parameter int   DEPTH = 8,
    parameter int   SLACK = 3,
    parameter dir_e DIR   = DIR_OUT,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             rd_en,
    output logic [WIDTH-1:0] rd_data,
    output logic [CNT_W-1:0] level,
    output logic             full,
    output logic             empty,
    output logic             warn,
    output logic             warn_rise,
    output logic             drop_pulse,
    output logic             under_pulse
);

    logic             push;
    logic             pop;
    logic [PTR_W-1:0] wptr;
    logic [PTR_W-1:0] rptr;
    logic [CNT_W-1:0] level_nxt;

    afifo_ctrl #(.DEPTH(DEPTH)) ctrl_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .rd_en     (rd_en),
        .push      (push),
        .pop       (pop),
        .wptr      (wptr),
        .rptr      (rptr),
        .level     (level),
        .level_nxt (level_nxt)
    );

    afifo_store #(.WIDTH(WIDTH), .DEPTH(DEPTH)) store_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .push    (push),
        .pop     (pop),
        .rd_en   (rd_en),
        .wptr    (wptr),
        .rptr    (rptr),
        .wr_data (wr_data),
        .rd_data (rd_data)
    );

    afifo_flags #(.DEPTH(DEPTH), .SLACK(SLACK), .DIR(DIR)) flags_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .rd_en       (rd_en),
        .push        (push),
        .pop         (pop),
        .level       (level),
        .level_nxt   (level_nxt),
        .full        (full),
        .empty       (empty),
        .warn        (warn),
        .warn_rise   (warn_rise),
        .drop_pulse  (drop_pulse),
        .under_pulse (under_pulse)
    );

    // R10
    full_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && rd_en && full) |=> (level == CNT_W'(DEPTH - 1) && drop_pulse));

    // R10
    empty_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && rd_en && empty) |=> (level == CNT_W'(1) && under_pulse));

endmodule

// File: tb/audio_word_fifo_tb_top.sv
`timescale 1ns/1ps
module audio_word_fifo_tb_top;
    import afifo_pkg::*;

    localparam int CLK_NS = 20;
    localparam int NVEC   = 24;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [15:0] wr_data = '0;

    logic [15:0] rd_data_o, rd_data_n;
    logic [3:0]  level_o, level_n;
    logic full_o, empty_o, warn_o, wrise_o, drop_o, under_o;
    logic full_n, empty_n, warn_n, wrise_n, drop_n, under_n;

    int total = 0;
    int bad   = 0;

    always #(CLK_NS/2) clk = ~clk;

    audio_word_fifo #(.DIR(DIR_OUT)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
        .rd_data(rd_data_o), .level(level_o), .full(full_o), .empty(empty_o),
        .warn(warn_o), .warn_rise(wrise_o), .drop_pulse(drop_o), .under_pulse(under_o)
    );

    audio_word_fifo #(.DIR(DIR_IN)) dut_in_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
        .rd_data(rd_data_n), .level(level_n), .full(full_n), .empty(empty_n),
        .warn(warn_n), .warn_rise(wrise_n), .drop_pulse(drop_n), .under_pulse(under_n)
    );

    // Vector: {wr, rd, wdata, check_rd, exp_rd, exp_level}
    localparam logic [38:0] VEC [NVEC] = '{
        {1'b0, 1'b1, 16'h0000, 1'b1, 16'hAAAA, 4'd0},  // empty read (R5)
        {1'b1, 1'b0, 16'h1111, 1'b0, 16'h0000, 4'd1},
        {1'b1, 1'b0, 16'h2222, 1'b0, 16'h0000, 4'd2},
        {1'b1, 1'b0, 16'h3333, 1'b0, 16'h0000, 4'd3},
        {1'b0, 1'b1, 16'h0000, 1'b1, 16'h1111, 4'd2},  // R2
        {1'b1, 1'b1, 16'h4444, 1'b1, 16'h2222, 4'd2},  // R9
        {1'b1, 1'b0, 16'h5555, 1'b0, 16'h0000, 4'd3},
        {1'b1, 1'b0, 16'h6666, 1'b0, 16'h0000, 4'd4},
        {1'b1, 1'b0, 16'h7777, 1'b0, 16'h0000, 4'd5},  // R6 warn rises
        {1'b1, 1'b0, 16'h8888, 1'b0, 16'h0000, 4'd6},
        {1'b1, 1'b0, 16'h9999, 1'b0, 16'h0000, 4'd7},
        {1'b1, 1'b0, 16'hAAA1, 1'b0, 16'h0000, 4'd8},  // R3 full
        {1'b1, 1'b0, 16'hBBBB, 1'b0, 16'h0000, 4'd8},  // R4 drop
        {1'b1, 1'b1, 16'hCCCC, 1'b1, 16'h3333, 4'd7},  // R10 full pair
        {1'b0, 1'b1, 16'h0000, 1'b1, 16'h4444, 4'd6},
        {1'b0, 1'b1, 16'h0000, 1'b1, 16'h5555, 4'd5},
        {1'b0, 1'b1, 16'h0000, 1'b1, 16'h6666, 4'd4},
        {1'b0, 1'b1, 16'h0000, 1'b1, 16'h7777, 4'd3},  // R7 warn rises
        {1'b0, 1'b1, 16'h0000, 1'b1, 16'h8888, 4'd2},
        {1'b0, 1'b1, 16'h0000, 1'b1, 16'h9999, 4'd1},
        {1'b0, 1'b1, 16'h0000, 1'b1, 16'hAAA1, 4'd0},  // R4 dropped words absent
        {1'b0, 1'b1, 16'h0000, 1'b1, 16'hAAAA, 4'd0},  // R5
        {1'b1, 1'b1, 16'h1234, 1'b1, 16'hAAAA, 4'd1},  // R10 empty pair
        {1'b0, 1'b1, 16'h0000, 1'b1, 16'h1234, 4'd0}
    };

    // Count one check and report a mismatch.
    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Drive strobes on the falling edge, let one rising edge pass, return at the next falling edge.
    task automatic step(input logic w, input logic r, input logic [15:0] d);
        wr_en = w; rd_en = r; wr_data = d;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
    endtask

    // Check the outputs that reset must set.
    task automatic reset_checks();
        check("R1 level", 32'(level_o), 0);
        check("R1 empty", 32'(empty_o), 1);
        check("R1 full", 32'(full_o), 0);
        check("R1 rd_data", 32'(rd_data_o), 0);
        check("R1 pulses", 32'({drop_o, under_o, wrise_o}), 0);
        check("R1 warn out", 32'(warn_o), 0);
        check("R1 warn in", 32'(warn_n), 1);
        check("R1 warn_rise in", 32'(wrise_n), 0);
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (200000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog: actual=expired expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int prev_lvl;
        repeat (3) @(posedge clk);
        @(negedge clk);
        reset_checks();
        rst_n = 1'b1;

        prev_lvl = 0;
        for (int i = 0; i < NVEC; i++) begin
            logic        w, r, chk;
            logic [15:0] d, erd;
            int          lvl;
            {w, r, d, chk, erd} = VEC[i][38:4];
            lvl = int'(VEC[i][3:0]);
            step(w, r, d);
            if (chk) check("R2/R5 rd_data", 32'(rd_data_o), 32'(erd));
            check("R3 level", 32'(level_o), 32'(lvl));
            check("R3 full", 32'(full_o), 32'(lvl == 8));
            check("R5 empty", 32'(empty_o), 32'(lvl == 0));
            check("R6 warn out", 32'(warn_o), 32'(lvl >= 5));
            check("R7 warn in", 32'(warn_n), 32'(lvl <= 3));
            check("R8 warn_rise out", 32'(wrise_o), 32'(prev_lvl < 5 && lvl >= 5));
            check("R8 warn_rise in", 32'(wrise_n), 32'(prev_lvl > 3 && lvl <= 3));
            check("R4 drop_pulse", 32'(drop_o), 32'(w && prev_lvl == 8));
            check("R5 under_pulse", 32'(under_o), 32'(r && prev_lvl == 0));
            check("R10 level in copy", 32'(level_n), 32'(lvl));
            prev_lvl = lvl;
        end

        // R2: with no read strobe, rd_data keeps the last word read.
        step(1'b0, 1'b0, 16'h0);
        check("R2 rd hold", 32'(rd_data_o), 32'h1234);
        check("R5 under_pulse clears", 32'(under_o), 0);

        // R1: reset in the middle of a fill clears the store.
        step(1'b1, 1'b0, 16'hDEAD);
        step(1'b1, 1'b0, 16'hBEEF);
        check("R1 pre-reset level", 32'(level_o), 2);
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        reset_checks();
        rst_n = 1'b1;
        step(1'b0, 1'b1, 16'h0);
        check("R5 read after reset", 32'(rd_data_o), 32'hAAAA);
        check("R5 level after reset read", 32'(level_o), 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule